// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is one eight-pin general-purpose I/O port that hangs off a microcontroller's special-function-register bus. Software sees three registers: an output latch, a per-pin drive-style register (push-pull or open-drain) and a per-pin input-style register (digital or analog). The port turns these settings into three control signals for each pad: a driver enable, a driven value and a weak pull-up enable. It takes the pad levels back in as inputs.

A read of the latch address does not return the latch. It returns the level seen at the pads, after a two-flop synchronizer. Pins set to analog read as 0 and never get a pull-up. The pull-up is also dropped whenever the pin is being driven low, so the pull-up and the driver never fight.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset the latch reads back as all ones at the pads (every pin driven low is absent), the input-style register is 0xFF (all digital) and the drive-style register is 0x00 (all open-drain).
- R2: A write with `bus_we` high stores `bus_wdata` on the next rising clock edge. The target is chosen by address: 0 is the latch, 1 is drive style, 2 is input style. A write to address 3 changes nothing, and a read of address 3 returns 0.
- R3: For each pin: a latch bit of 0 gives `pad_oe`=1 and `pad_do`=0. A latch bit of 1 with drive-style bit 1 (push-pull) gives `pad_oe`=1 and `pad_do`=1. A latch bit of 1 with drive-style bit 0 (open-drain) gives `pad_oe`=0.
- R4: A read of address 0 returns the `pad_in` level sampled two rising edges earlier. The latch contents do not affect it.
- R5: A pin whose input-style bit is 0 (analog) reads as 0 at address 0, whatever its pad level.
- R6: An analog pin never has `pad_pu` set. Its drive still follows R3.
- R7: A digital pin has `pad_pu`=1 unless `pu_disable` is high or the pin is driven low.
- R8: Reads of addresses 1 and 2 return the drive-style and input-style registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Combinational read data for `bus_addr` |
| pu_disable | input | 1 | Global weak pull-up disable |
| pad_in | input | WIDTH | Pad levels |
| pad_oe | output | WIDTH | Per-pin driver enable |
| pad_do | output | WIDTH | Per-pin driven value |
| pad_pu | output | WIDTH | Per-pin weak pull-up enable |

## Verification
A register write is seen one rising edge after the strobe. The pad controls and the readback of the mode registers are combinational from the stored registers, so the bench samples them 1 ns after that edge. A `pad_in` change first shows in the read data two edges later. The bench checks that the old value is still returned after one edge and that the new value appears after the second. Random writes and random pad levels are always followed by two edges before any read is compared against the bench's model.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DATA  = 2'd0,
        SEL_DRIVE = 2'd1,
        SEL_INPUT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic oe;
        logic dout;
        logic pu;
    } pin_drive_t;

    function automatic pin_drive_t pin_resolve(input logic latch,
                                               input logic push_pull,
                                               input logic digital,
                                               input logic pu_off);
        pin_drive_t r;
        r.oe   = ~latch | push_pull;
        r.dout = latch;
        r.pu   = digital & ~pu_off & ~(r.oe & ~latch);
        return r;
    endfunction

endpackage

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  reg_sel_e          sel,
    input  logic [WIDTH-1:0]  wdata,
    output logic [WIDTH-1:0]  lat_q,
    output logic [WIDTH-1:0]  om_q,
    output logic [WIDTH-1:0]  im_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '1;
            om_q  <= '0;
            im_q  <= '1;
        end else if (we) begin
            case (sel)
                SEL_DATA:  lat_q <= wdata;
                SEL_DRIVE: om_q  <= wdata;
                SEL_INPUT: im_q  <= wdata;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lat,
    input  logic [WIDTH-1:0] om,
    input  logic [WIDTH-1:0] im,
    input  logic             pu_off,
    output logic [WIDTH-1:0] oe,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] pu
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        pin_drive_t drv;
        always_comb drv = pin_resolve(lat[p], om[p], im[p], pu_off);
        assign oe[p]   = drv.oe;
        assign dout[p] = drv.dout;
        assign pu[p]   = drv.pu;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              pu_disable,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_do,
    output logic [WIDTH-1:0]  pad_pu
);
    reg_sel_e         sel;
    logic [WIDTH-1:0] lat_q, om_q, im_q, sync_q;

    assign sel = reg_sel_e'(bus_addr);

    gpio_regfile #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .sel(sel), .wdata(bus_wdata),
        .lat_q(lat_q), .om_q(om_q), .im_q(im_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(sync_q)
    );

    gpio_pin_ctrl #(.WIDTH(WIDTH)) u_pins (
        .lat(lat_q), .om(om_q), .im(im_q), .pu_off(pu_disable),
        .oe(pad_oe), .dout(pad_do), .pu(pad_pu)
    );

    always_comb begin
        case (sel)
            SEL_DATA:  bus_rdata = sync_q & im_q;
            SEL_DRIVE: bus_rdata = om_q;
            SEL_INPUT: bus_rdata = im_q;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  bus_rdata,
    input logic              pu_disable,
    input logic [WIDTH-1:0]  pad_in,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_do,
    input logic [WIDTH-1:0]  pad_pu,
    input logic [WIDTH-1:0]  lat_q,
    input logic [WIDTH-1:0]  im_q,
    input logic [WIDTH-1:0]  sync_q
);
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst) since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r2_latch_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_DATA) |=> (lat_q == $past(bus_wdata)));

    a_r2_none_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == SEL_NONE) |=> $stable(lat_q) && $stable(im_q));

    a_r3_low_driven: assert property (@(posedge clk) disable iff (rst)
        ((~lat_q & ~(pad_oe & ~pad_do)) == '0));

    a_r4_sync_depth: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (sync_q == $past(pad_in, 2)));

    a_r5_analog_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == SEL_DATA) |-> ((bus_rdata & ~im_q) == '0));

    a_r6_analog_no_pull: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu & ~im_q) == '0));

    a_r7_pull_no_fight: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu & pad_oe & ~pad_do) == '0));

    a_r7_global_off: assert property (@(posedge clk) disable iff (rst)
        pu_disable |-> (pad_pu == '0));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
    localparam int W = 8;

    logic         clk = 0;
    logic         rst = 1;
    logic [1:0]   bus_addr = 0;
    logic         bus_we = 0;
    logic [W-1:0] bus_wdata = 0;
    logic [W-1:0] bus_rdata;
    logic         pu_disable = 0;
    logic [W-1:0] pad_in = 0;
    logic [W-1:0] pad_oe, pad_do, pad_pu;

    int n_run = 0, n_fail = 0;
    logic [W-1:0] m_lat, m_om, m_im, m_pad;
    logic         done = 0;

    always #5 clk = ~clk;

    gpio_port #(.WIDTH(W)) uut (.*);

    function automatic logic [W-1:0] f_oe(logic [W-1:0] l, logic [W-1:0] o);
        return ~l | o;
    endfunction
    function automatic logic [W-1:0] f_pu(logic [W-1:0] l, logic [W-1:0] o,
                                          logic [W-1:0] i, logic d);
        logic [W-1:0] r;
        for (int b = 0; b < W; b++)
            r[b] = i[b] & ~d & l[b];
        return r;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 0;
        case (a)
            2'd0: m_lat = d;
            2'd1: m_om  = d;
            2'd2: m_im  = d;
            default: ;
        endcase
    endtask

    task automatic rd(logic [1:0] a, output logic [W-1:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    task automatic check_all(string tag);
        logic [W-1:0] v;
        chk({"R3 oe ", tag}, pad_oe, f_oe(m_lat, m_om));
        chk({"R3 do ", tag}, pad_do, m_lat);
        chk({"R7 pu ", tag}, pad_pu, f_pu(m_lat, m_om, m_im, pu_disable));
        rd(2'd0, v); chk({"R4 R5 data read ", tag}, v, m_pad & m_im);
        rd(2'd1, v); chk({"R8 drive read ", tag}, v, m_om);
        rd(2'd2, v); chk({"R8 input read ", tag}, v, m_im);
        rd(2'd3, v); chk({"R2 empty read ", tag}, v, '0);
    endtask

    initial begin
        #1500000;
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        void'($urandom(32'h5eed_1234));
        m_lat = '1; m_om = '0; m_im = '1; m_pad = 8'hA5;
        pad_in = m_pad;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        repeat (2) @(posedge clk); #1;
        // R1 reset state
        chk("R1 latch reset oe", pad_oe, 8'h00);
        rd(2'd1, v); chk("R1 drive reset", v, 8'h00);
        rd(2'd2, v); chk("R1 input reset", v, 8'hFF);
        check_all("reset");

        // R4 two-edge latency, latch has no effect on read
        wr(2'd0, 8'h0F);
        @(negedge clk); pad_in = 8'h3C;
        @(posedge clk); #1;
        rd(2'd0, v); chk("R4 one edge old", v, 8'hA5);
        @(posedge clk); #1;
        rd(2'd0, v); chk("R4 two edges new", v, 8'h3C);
        m_pad = 8'h3C;

        // R3 drive modes
        wr(2'd1, 8'hF0);
        check_all("push-pull mix");
        // R5 R6 analog pins
        wr(2'd2, 8'h55);
        check_all("analog mix");
        chk("R6 analog no pull", pad_pu & ~m_im, '0);
        // R7 global disable
        @(negedge clk); pu_disable = 1; #1;
        check_all("pu disabled");
        @(negedge clk); pu_disable = 0;
        // R2 address 3 write ignored
        wr(2'd3, 8'h00);
        check_all("empty write");

        for (int it = 0; it < 400; it++) begin
            logic [1:0] a;
            a = 2'($urandom % 4);
            wr(a, W'($urandom));
            @(negedge clk);
            pad_in = W'($urandom);
            pu_disable = ($urandom % 5) == 0;
            @(posedge clk); @(posedge clk); #1;
            m_pad = pad_in;
            check_all("random");
        end

        // R1 reset again restores defaults
        @(negedge clk); rst = 1;
        @(posedge clk); #1; rst = 0;
        m_lat = '1; m_om = '0; m_im = '1; m_pad = 8'h00;
        pu_disable = 0;
        check_all("re-reset");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule